// File: doc/BRIEF.md
# Conditional Instruction Class Decoder

This block sorts a 32-bit instruction word into one of nineteen instruction classes and decides, ahead of any execution stage, whether the word runs at all. Each input beat carries the word, the four arithmetic flags and the interrupt state. The block returns a one-hot class vector, a condition-pass flag, an undefined-word flag and a trap request. The trap request is either an interrupt taken before decode or a software trap.

The class patterns are masks with don't-care bits, and several of them overlap. A word that fits more than one pattern takes the class listed first, so the order of the table is part of the behaviour. The top four bits of the word pick a test on the flags. When the test fails, the word produces no class, no undefined flag and no trap. A pending, unmasked interrupt overrides both the decode and the condition test.

Data flows through a one-deep valid/ready register stage. A beat is accepted when `in_valid` and `in_ready` are both high. The result is shown on the cycle after acceptance and stays stable while `out_valid` is high and `out_ready` is low. `in_ready` is high whenever the output register is empty or is being drained on the same cycle, so a stalled consumer pushes back on the producer within that cycle.

Top module: `insn_class_decoder`

## Requirements
- R1: A beat accepted on a clock edge appears with `out_valid` high after that edge. `in_ready` is low exactly while `out_valid` is high and `out_ready` is low. A result held under back-pressure does not change.
- R2: Condition field word[31:28] with flags {N,Z,C,V} = in_flags[3:0]: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always.
- R3: Condition code 15 never passes.
- R4: When irq_line is high and irq_mask is low, out_take_irq=1, out_cond_pass=0, out_class=0 and out_undef=0. The trap goes to address 0x18 in mode code 0x12, whatever the word and the flags.
- R5: A passing word sets exactly one out_class bit, using the first match in index order: 0 exchange-branch (27:20=00010010, 7:4=0001); 1 multiply (27:22=0, 7:4=1001); 2 long multiply (27:23=00001, 7:4=1001); 3 status read (27:23=00010, 21:20=00, 7:4=0000); 4 swap (same but 7:4=1001); 5 status write from register (27:23=00010, 21:20=10, 7:4=0000); 6 status write from immediate (27:23=00110, 21:20=10); 7/8 signed load by register/immediate (27:25=000, bit20=1, 7:6=11, bit4=1, bit22=0/1); 9/10 halfword by register/immediate (27:25=000, 7:4=1011, bit22=0/1); 11 ALU immediate shift (27:25=000, bit4=0); 12 ALU register shift (27:25=000, bit7=0, bit4=1); 13 ALU immediate (27:25=001); 14 load/store immediate offset (27:25=010); 15 load/store register offset (27:25=011, bit4=0); 16 block transfer (27:25=100); 17 branch (27:25=101); 18 software trap (27:24=1111).
- R6: A word that fits several patterns is given the lowest index among them. For example, 7:4=0000 with 27:20=00010000 is class 3, not class 11.
- R7: A passing word that fits no pattern sets out_undef=1 and out_class=0.
- R8: A passing class-18 word sets out_trap=1 with address 0x08 and mode code 0x13. A word with no trap gives out_trap=0, address 0 and mode 0.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_word | input | 32 | Instruction word |
| in_flags | input | 4 | Flags {N,Z,C,V} |
| irq_line | input | 1 | Interrupt request level |
| irq_mask | input | 1 | Interrupt disable |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_class | output | 19 | One-hot class, index as in R5 |
| out_cond_pass | output | 1 | Condition passed and no interrupt |
| out_undef | output | 1 | Passing word matched no class |
| out_take_irq | output | 1 | Interrupt taken ahead of decode |
| out_trap | output | 1 | Trap requested (interrupt or software) |
| out_trap_addr | output | 32 | Trap vector address |
| out_trap_mode | output | 5 | Trap mode code |

## Verification
The main sweep takes every value of bits 27:20 together with every value of bits 7:4, with the condition set to always. That covers each overlap region, so it shows whether the right pattern wins at every class boundary and where undefined words lie. A second sweep takes all sixteen condition codes against all sixteen flag combinations. It separates the flag test of each code and confirms that code 15 never passes. Interrupt beats are sent with failing and passing conditions and with the mask both set and clear, and a back-pressure sequence checks that a held result stays put while the next beat waits.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int NUM_CLASSES = 19;
  localparam int WORD_W      = 32;
  localparam int COND_MSB    = 31;

  localparam int CLS_SWTRAP  = 18;

  localparam logic [31:0] IRQ_VECTOR  = 32'h0000_0018;
  localparam logic [4:0]  IRQ_MODE    = 5'h12;
  localparam logic [31:0] SWT_VECTOR  = 32'h0000_0008;
  localparam logic [4:0]  SWT_MODE    = 5'h13;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Care bits for each class, listed in priority order.
  function automatic logic [31:0] class_mask(input int idx);
    case (idx)
      0:  class_mask = 32'h0FF0_00F0;
      1:  class_mask = 32'h0FC0_00F0;
      2:  class_mask = 32'h0F80_00F0;
      3:  class_mask = 32'h0FB0_00F0;
      4:  class_mask = 32'h0FB0_00F0;
      5:  class_mask = 32'h0FB0_00F0;
      6:  class_mask = 32'h0FB0_0000;
      7:  class_mask = 32'h0E50_00D0;
      8:  class_mask = 32'h0E50_00D0;
      9:  class_mask = 32'h0E40_00F0;
      10: class_mask = 32'h0E40_00F0;
      11: class_mask = 32'h0E00_0010;
      12: class_mask = 32'h0E00_0090;
      13: class_mask = 32'h0E00_0000;
      14: class_mask = 32'h0E00_0000;
      15: class_mask = 32'h0E00_0010;
      16: class_mask = 32'h0E00_0000;
      17: class_mask = 32'h0E00_0000;
      18: class_mask = 32'h0F00_0000;
      default: class_mask = 32'h0;
    endcase
  endfunction

  // Required value of the care bits for each class.
  function automatic logic [31:0] class_value(input int idx);
    case (idx)
      0:  class_value = 32'h0120_0010;
      1:  class_value = 32'h0000_0090;
      2:  class_value = 32'h0080_0090;
      3:  class_value = 32'h0100_0000;
      4:  class_value = 32'h0100_0090;
      5:  class_value = 32'h0120_0000;
      6:  class_value = 32'h0320_0000;
      7:  class_value = 32'h0010_00D0;
      8:  class_value = 32'h0050_00D0;
      9:  class_value = 32'h0000_00B0;
      10: class_value = 32'h0040_00B0;
      11: class_value = 32'h0000_0000;
      12: class_value = 32'h0000_0010;
      13: class_value = 32'h0200_0000;
      14: class_value = 32'h0400_0000;
      15: class_value = 32'h0600_0000;
      16: class_value = 32'h0800_0000;
      17: class_value = 32'h0A00_0000;
      18: class_value = 32'h0F00_0000;
      default: class_value = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/icd_pattern_bank.sv
module icd_pattern_bank
  import icd_pkg::*;
#(
  parameter int N_PAT = NUM_CLASSES,
  parameter int W     = WORD_W
) (
  input  logic [W-1:0]     word,
  output logic [N_PAT-1:0] hits
);
  for (genvar g = 0; g < N_PAT; g++) begin : g_pat
    localparam logic [W-1:0] MASK = W'(class_mask(g));
    localparam logic [W-1:0] VAL  = W'(class_value(g));
    assign hits[g] = ((word & MASK) == (VAL & MASK));
  end
endmodule

// File: rtl/icd_first_hit.sv
module icd_first_hit #(
  parameter int N = 19
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_pick
    assign grant[g]     = req[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | req[g];
  end
  assign any = blocked[N];
endmodule

// File: rtl/icd_cond_eval.sv
module icd_cond_eval
  import icd_pkg::*;
(
  input  logic [3:0] code,
  input  flags_t     flags,
  output logic       pass
);
  logic base;
  logic n_eq_v;
  assign n_eq_v = (flags.n == flags.v);

  // Even/odd pairs share a base test; the low bit inverts it, except code 15.
  always_comb begin
    case (code[3:1])
      3'd0: base = flags.z;
      3'd1: base = flags.c;
      3'd2: base = flags.n;
      3'd3: base = flags.v;
      3'd4: base = flags.c & ~flags.z;
      3'd5: base = n_eq_v;
      3'd6: base = ~flags.z & n_eq_v;
      default: base = 1'b1;
    endcase
    if (code == 4'd15)      pass = 1'b0;
    else if (code == 4'd14) pass = 1'b1;
    else                    pass = base ^ code[0];
  end
endmodule

// File: rtl/insn_class_decoder.sv
module insn_class_decoder
  import icd_pkg::*;
#(
  parameter int N_CLS = NUM_CLASSES,
  parameter int W     = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_word,
  input  logic [3:0]       in_flags,
  input  logic             irq_line,
  input  logic             irq_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [N_CLS-1:0] out_class,
  output logic             out_cond_pass,
  output logic             out_undef,
  output logic             out_take_irq,
  output logic             out_trap,
  output logic [31:0]      out_trap_addr,
  output logic [4:0]       out_trap_mode
);
  localparam int COND_LSB = W - 4;

  logic [N_CLS-1:0] hits;
  logic [N_CLS-1:0] first;
  logic             any_hit;
  logic             cond_ok;
  logic             irq_now;
  logic             runs;

  logic [N_CLS-1:0] nx_class;
  logic             nx_pass;
  logic             nx_undef;
  logic             nx_trap;
  logic [31:0]      nx_addr;
  logic [4:0]       nx_mode;
  logic             accept;

  icd_pattern_bank #(.N_PAT(N_CLS), .W(W)) u_bank (
    .word (in_word),
    .hits (hits)
  );

  icd_first_hit #(.N(N_CLS)) u_pick (
    .req   (hits),
    .grant (first),
    .any   (any_hit)
  );

  icd_cond_eval u_cond (
    .code  (in_word[W-1:COND_LSB]),
    .flags (flags_t'(in_flags)),
    .pass  (cond_ok)
  );

  assign irq_now = irq_line & ~irq_mask;
  assign runs    = cond_ok & ~irq_now;

  always_comb begin
    nx_class = runs ? first : '0;
    nx_pass  = runs;
    nx_undef = runs & ~any_hit;
    nx_trap  = 1'b0;
    nx_addr  = 32'h0;
    nx_mode  = 5'h0;
    if (irq_now) begin
      nx_trap = 1'b1;
      nx_addr = IRQ_VECTOR;
      nx_mode = IRQ_MODE;
    end else if (runs && first[CLS_SWTRAP]) begin
      nx_trap = 1'b1;
      nx_addr = SWT_VECTOR;
      nx_mode = SWT_MODE;
    end
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_class     <= '0;
      out_cond_pass <= 1'b0;
      out_undef     <= 1'b0;
      out_take_irq  <= 1'b0;
      out_trap      <= 1'b0;
      out_trap_addr <= 32'h0;
      out_trap_mode <= 5'h0;
    end else if (accept) begin
      out_class     <= nx_class;
      out_cond_pass <= nx_pass;
      out_undef     <= nx_undef;
      out_take_irq  <= irq_now;
      out_trap      <= nx_trap;
      out_trap_addr <= nx_addr;
      out_trap_mode <= nx_mode;
    end
  end
endmodule

// File: rtl/insn_class_decoder_chk.sv
module insn_class_decoder_chk #(
  parameter int N_CLS = 19,
  parameter int W     = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [W-1:0]     in_word,
  input logic             irq_line,
  input logic             irq_mask,
  input logic             out_valid,
  input logic             out_ready,
  input logic [N_CLS-1:0] out_class,
  input logic             out_cond_pass,
  input logic             out_undef,
  input logic             out_take_irq,
  input logic             out_trap,
  input logic [31:0]      out_trap_addr,
  input logic [4:0]       out_trap_mode
);
  logic       seen_never;
  logic       seen_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_never <= 1'b0;
      seen_irq   <= 1'b0;
    end else if (in_valid && in_ready) begin
      seen_never <= (in_word[W-1:W-4] == 4'hF);
      seen_irq   <= irq_line & ~irq_mask;
    end
  end

  // R1: accepted beat shows up next cycle
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1: held result is stable under back-pressure
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class)
      && $stable(out_cond_pass) && $stable(out_undef) && $stable(out_trap));

  // R2: failed condition has no other effect
  a_r2_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_cond_pass && !out_take_irq |->
      out_class == '0 && !out_undef && !out_trap);

  // R3: code 15 never passes
  a_r3_never: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen_never |-> !out_cond_pass);

  // R4: interrupt wins over decode
  a_r4_irq: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen_irq |-> out_take_irq && out_class == '0 && !out_cond_pass
      && !out_undef && out_trap && out_trap_addr == 32'h18 && out_trap_mode == 5'h12);

  // R5: at most one class
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_class));

  // R5: a passing word yields a class or the undefined flag
  a_r5_cover: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cond_pass |-> ($countones(out_class) == 1) != out_undef);

  // R7: undefined excludes a class
  a_r7_undef: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> out_class == '0 && out_cond_pass);

  // R8: software trap vector
  a_r8_swtrap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class[N_CLS-1] |-> out_trap && out_trap_addr == 32'h08
      && out_trap_mode == 5'h13);
endmodule

bind insn_class_decoder insn_class_decoder_chk #(.N_CLS(N_CLS), .W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_word       (in_word),
  .irq_line      (irq_line),
  .irq_mask      (irq_mask),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_class     (out_class),
  .out_cond_pass (out_cond_pass),
  .out_undef     (out_undef),
  .out_take_irq  (out_take_irq),
  .out_trap      (out_trap),
  .out_trap_addr (out_trap_addr),
  .out_trap_mode (out_trap_mode)
);

// File: tb/insn_class_decoder_test.sv
`timescale 1ns/1ps
module insn_class_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [3:0]  in_flags = '0;
  logic        irq_line = 1'b0;
  logic        irq_mask = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [18:0] out_class;
  logic        out_cond_pass;
  logic        out_undef;
  logic        out_take_irq;
  logic        out_trap;
  logic [31:0] out_trap_addr;
  logic [4:0]  out_trap_mode;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  insn_class_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_flags(in_flags), .irq_line(irq_line), .irq_mask(irq_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
    .out_cond_pass(out_cond_pass), .out_undef(out_undef), .out_take_irq(out_take_irq),
    .out_trap(out_trap), .out_trap_addr(out_trap_addr), .out_trap_mode(out_trap_mode)
  );

  // Class index per R5/R6, 19 = no match.
  function automatic int ref_class(input logic [31:0] w);
    logic [7:0] op = w[27:20];
    logic [3:0] lo = w[7:4];
    if (op == 8'h12 && lo == 4'h1) return 0;
    if (w[27:22] == 6'd0 && lo == 4'h9) return 1;
    if (w[27:23] == 5'b00001 && lo == 4'h9) return 2;
    if (w[27:23] == 5'b00010 && w[21:20] == 2'b00 && lo == 4'h0) return 3;
    if (w[27:23] == 5'b00010 && w[21:20] == 2'b00 && lo == 4'h9) return 4;
    if (w[27:23] == 5'b00010 && w[21:20] == 2'b10 && lo == 4'h0) return 5;
    if (w[27:23] == 5'b00110 && w[21:20] == 2'b10) return 6;
    if (w[27:25] == 3'b000 && w[20] && lo[3:2] == 2'b11 && lo[0]) return w[22] ? 8 : 7;
    if (w[27:25] == 3'b000 && lo == 4'hB) return w[22] ? 10 : 9;
    if (w[27:25] == 3'b000 && !w[4]) return 11;
    if (w[27:25] == 3'b000 && !w[7] && w[4]) return 12;
    if (w[27:25] == 3'b001) return 13;
    if (w[27:25] == 3'b010) return 14;
    if (w[27:25] == 3'b011 && !w[4]) return 15;
    if (w[27:25] == 3'b100) return 16;
    if (w[27:25] == 3'b101) return 17;
    if (w[27:24] == 4'hF) return 18;
    return 19;
  endfunction

  // Flag test per R2/R3, f = {N,Z,C,V}.
  function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
    logic n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;           1: return !z;
      2: return cy;          3: return !cy;
      4: return n;           5: return !n;
      6: return v;           7: return !v;
      8: return cy && !z;    9: return !cy || z;
      10: return n == v;     11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one beat with out_ready high, sample after the capturing edge.
  task automatic send(input logic [31:0] w, input logic [3:0] f,
                      input logic irq, input logic msk);
    @(negedge clk);
    in_word = w; in_flags = f; irq_line = irq; irq_mask = msk; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_result(input logic [31:0] w, input logic [3:0] f,
                              input logic irq, input logic msk, input string req);
    logic        take = irq && !msk;
    logic        run  = ref_cond(w[31:28], f) && !take;
    int          k    = ref_class(w);
    logic [18:0] ec   = (run && k < 19) ? (19'd1 << k) : 19'd0;
    logic        eu   = run && k == 19;
    logic        et   = take || (run && k == 18);
    logic [31:0] ea   = take ? 32'h18 : (et ? 32'h08 : 32'h0);
    logic [4:0]  em   = take ? 5'h12 : (et ? 5'h13 : 5'h0);
    logic [63:0] act  = {out_valid, out_class, out_cond_pass, out_undef, out_take_irq,
                         out_trap, out_trap_addr[7:0], out_trap_mode};
    logic [63:0] exp  = {1'b1, ec, run, eu, take, et, ea[7:0], em};
    check(act == exp && out_trap_addr == ea, req, "result", act, exp);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9", "reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R7 R8: sweep bits 27:20 and 7:4 with always-condition
    for (int op = 0; op < 256; op++) begin
      for (int lo = 0; lo < 16; lo++) begin
        logic [31:0] w = {4'hE, 8'(op), 4'(op + lo), 8'hA5, 4'(lo), 4'(15 - lo)};
        send(w, 4'(lo), 1'b0, 1'b1);
        check_result(w, 4'(lo), 1'b0, 1'b1, "R5/R6/R7/R8");
      end
    end

    // R2 R3: every condition against every flag set
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] w = {4'(c), 28'hA00_1234};
        send(w, 4'(f), 1'b0, 1'b0);
        check_result(w, 4'(f), 1'b0, 1'b0, c == 15 ? "R3" : "R2");
      end
    end

    // R4: interrupt overrides failing, passing, undefined and trap words
    for (int i = 0; i < 4; i++) begin
      logic [31:0] wl [4] = '{32'h0A00_0000, 32'hEF00_0001, 32'hE600_0010, 32'hF120_0011};
      send(wl[i], 4'h0, 1'b1, 1'b0);
      check_result(wl[i], 4'h0, 1'b1, 1'b0, "R4");
      send(wl[i], 4'h0, 1'b1, 1'b1);
      check_result(wl[i], 4'h0, 1'b1, 1'b1, "R4 masked");
    end

    // R1: back-pressure hold
    @(negedge clk);
    out_ready = 1'b0;
    in_word = 32'hEA00_0000; in_flags = 4'h0; irq_line = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && in_ready == 1'b0, "R1", "stall ready", {out_valid, in_ready}, 2'b10);
    in_word = 32'hE280_0001;
    @(negedge clk);
    @(negedge clk);
    check_result(32'hEA00_0000, 4'h0, 1'b0, 1'b1, "R1 held");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(32'hE280_0001, 4'h0, 1'b0, 1'b1, "R1 next");
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready, "R1", "drained", {out_valid, in_ready}, 2'b01);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule